// File: doc/BRIEF.md
# Slot-Based Interrupt Router

This block sits between the interrupt pins of the devices on a PCI bus and one interrupt input of the CPU. A device asks for service on one of its four pins, INTA to INTD, which are numbered 0 to 3. It also gives its slot number, which is the upper five bits of its device/function number. The router turns the pair into an interrupt number through a fixed table:

- Onboard slots get dedicated lines.
- The plug-in slots share a band of lines, with the pins rotated by slot position.
- Any slot the table does not know passes the pin number through unchanged.

Internal lines start at a base number of 32. A line is internal when its mapped number lies between the base and the base plus 31. For an internal line, two configuration words decide what the CPU sees, each holding one bit per line. If the line's edge bit is set, the CPU output gives a single-cycle pulse. If it is clear, the CPU output is driven to the line's polarity bit and stays there.

The routing path is combinational, so the mapped number is valid in the same cycle as the request. The CPU output is a flop. It changes on the clock edge that samples a request.

Top module: `slot_irq_router`

## Requirements
- R1: While `rst` is high, and on the first edge at which it is sampled high, `cpu_irq` becomes 0.
- R2: A request from slot 5 maps to 32 + pin.
- R3: A request from slot 6 maps to 36, and one from slot 7 maps to 37, whatever the pin.
- R4: A request from slot 8, 9, 10, 11 or 12 maps to 38 + (slot − 8) + pin.
- R5: A request from any other slot maps to the pin number itself (0 to 3).
- R6: If a request's mapped number is in 32..63 and bit (number − 32) of `edge_cfg` is set, `cpu_irq` is 1 in the cycle after the request. It then returns to 0 in the next cycle, unless another internal request arrives.
- R7: If a request's mapped number is in 32..63, bit (number − 32) of `edge_cfg` is clear and the same bit of `pol_cfg` is set, `cpu_irq` becomes 1. It holds that value through idle cycles.
- R8: If a request's mapped number is in 32..63 and both bit (number − 32) of `edge_cfg` and the same bit of `pol_cfg` are clear, `cpu_irq` becomes 0.
- R9: A request whose mapped number is outside 32..63 leaves a level-driven `cpu_irq` unchanged.
- R10: Pulse requests on consecutive cycles each keep `cpu_irq` at 1 in the following cycle. The output falls only after the last of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Interrupt request strobe, one cycle per request |
| dev_slot | input | 5 | Slot number of the requesting device (device/function number shifted right by 3) |
| dev_pin | input | 2 | Interrupt pin of the device, 0 = INTA to 3 = INTD |
| edge_cfg | input | 32 | One bit per internal line: 1 = pulse output, 0 = level output |
| pol_cfg | input | 32 | One bit per internal line: level driven onto the CPU output in level mode |
| irq_num | output | 8 | Mapped interrupt number, combinational from slot and pin |
| cpu_irq | output | 1 | Registered CPU interrupt output |

## Verification
The hardest situations to reach are the interactions between a pulse and what follows it. Examples are a pulse that arrives while a level output is high, back-to-back pulses, and a pass-through (non-internal) request in the cycle right after a pulse. In that last case the trailing fall must still happen, even though the request itself has no effect.

The stimulus raises the level output first and then sends a pulse. It issues pulse requests on consecutive cycles. It follows a pulse at once with a request from an unknown slot.

A scoreboard receives one expected output value per driven cycle, so every one of these cycle-by-cycle sequences is compared without gaps.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;

  // Per-request view of the selected internal line.
  typedef struct packed {
    logic hit;       // mapped number lies in the internal window
    logic edge_sel;  // selected line is in pulse mode
    logic pol_sel;   // level to drive when in level mode
  } line_sel_t;

endpackage

// File: rtl/slot_irq_map.sv
module slot_irq_map #(
  parameter int SLOT_W      = 5,
  parameter int PIN_W       = 2,
  parameter int NUM_W       = 8,
  parameter int IRQ_BASE    = 32,
  parameter int SHARED_SLOT = 5,
  parameter int GFX_SLOT    = 6,
  parameter int GFX_OFS     = 4,
  parameter int NIC_SLOT    = 7,
  parameter int NIC_OFS     = 5,
  parameter int PLUG_FIRST  = 8,
  parameter int PLUG_LAST   = 12,
  parameter int PLUG_OFS    = 6
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [PIN_W-1:0]  pin,
  output logic [NUM_W-1:0]  irq_num
);

  localparam int PIN_COUNT = 1 << PIN_W;

  int slot_i;
  int pin_i;
  int num_i;

  always_comb begin
    slot_i = int'(slot);
    pin_i  = int'(pin);
    if (slot_i == SHARED_SLOT) begin
      num_i = IRQ_BASE + (pin_i % PIN_COUNT);
    end else if (slot_i == GFX_SLOT) begin
      num_i = IRQ_BASE + GFX_OFS;
    end else if (slot_i == NIC_SLOT) begin
      num_i = IRQ_BASE + NIC_OFS;
    end else if (slot_i >= PLUG_FIRST && slot_i <= PLUG_LAST) begin
      num_i = IRQ_BASE + PLUG_OFS + (slot_i - PLUG_FIRST) + pin_i;
    end else begin
      num_i = pin_i;
    end
    irq_num = NUM_W'(num_i);
  end

endmodule

// File: rtl/slot_irq_line_sel.sv
module slot_irq_line_sel
  import slot_irq_pkg::*;
#(
  parameter int NUM_W    = 8,
  parameter int IRQ_BASE = 32,
  parameter int LINES    = 32
) (
  input  logic [NUM_W-1:0]          irq_num,
  input  logic [LINES-1:0]          edge_cfg,
  input  logic [LINES-1:0]          pol_cfg,
  output logic [$clog2(LINES)-1:0]  line_idx,
  output line_sel_t                 sel
);

  localparam int LINE_W = $clog2(LINES);
  localparam logic [NUM_W-1:0] LO_NUM = NUM_W'(IRQ_BASE);
  localparam logic [NUM_W-1:0] HI_NUM = NUM_W'(IRQ_BASE + LINES);

  logic             in_window;
  logic [NUM_W-1:0] rel_num;
  logic [LINES-1:0] onehot;

  assign in_window = (irq_num >= LO_NUM) && (irq_num < HI_NUM);
  assign rel_num   = irq_num - LO_NUM;
  assign line_idx  = rel_num[LINE_W-1:0];

  for (genvar g = 0; g < LINES; g++) begin : g_dec
    assign onehot[g] = in_window && (line_idx == LINE_W'(g));
  end

  assign sel.hit      = in_window;
  assign sel.edge_sel = |(onehot & edge_cfg);
  assign sel.pol_sel  = |(onehot & pol_cfg);

endmodule

// File: rtl/slot_irq_drive.sv
module slot_irq_drive
  import slot_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req_valid,
  input  line_sel_t sel,
  output logic      cpu_irq
);

  logic pulse_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq  <= 1'b0;
      pulse_on <= 1'b0;
    end else if (req_valid && sel.hit) begin
      if (sel.edge_sel) begin
        cpu_irq  <= 1'b1;
        pulse_on <= 1'b1;
      end else begin
        cpu_irq  <= sel.pol_sel;
        pulse_on <= 1'b0;
      end
    end else if (pulse_on) begin
      cpu_irq  <= 1'b0;
      pulse_on <= 1'b0;
    end
  end

endmodule

// File: rtl/slot_irq_router.sv
module slot_irq_router
  import slot_irq_pkg::*;
#(
  parameter int SLOT_W      = 5,
  parameter int PIN_W       = 2,
  parameter int NUM_W       = 8,
  parameter int IRQ_BASE    = 32,
  parameter int LINES       = 32,
  parameter int SHARED_SLOT = 5,
  parameter int GFX_SLOT    = 6,
  parameter int GFX_OFS     = 4,
  parameter int NIC_SLOT    = 7,
  parameter int NIC_OFS     = 5,
  parameter int PLUG_FIRST  = 8,
  parameter int PLUG_LAST   = 12,
  parameter int PLUG_OFS    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [SLOT_W-1:0] dev_slot,
  input  logic [PIN_W-1:0]  dev_pin,
  input  logic [LINES-1:0]  edge_cfg,
  input  logic [LINES-1:0]  pol_cfg,
  output logic [NUM_W-1:0]  irq_num,
  output logic              cpu_irq
);

  localparam int LINE_W = $clog2(LINES);

  logic [LINE_W-1:0] line_idx;
  line_sel_t         sel;
  logic              line_hit;

  slot_irq_map #(
    .SLOT_W(SLOT_W), .PIN_W(PIN_W), .NUM_W(NUM_W), .IRQ_BASE(IRQ_BASE),
    .SHARED_SLOT(SHARED_SLOT), .GFX_SLOT(GFX_SLOT), .GFX_OFS(GFX_OFS),
    .NIC_SLOT(NIC_SLOT), .NIC_OFS(NIC_OFS), .PLUG_FIRST(PLUG_FIRST),
    .PLUG_LAST(PLUG_LAST), .PLUG_OFS(PLUG_OFS)
  ) u_map (
    .slot    (dev_slot),
    .pin     (dev_pin),
    .irq_num (irq_num)
  );

  slot_irq_line_sel #(
    .NUM_W(NUM_W), .IRQ_BASE(IRQ_BASE), .LINES(LINES)
  ) u_sel (
    .irq_num  (irq_num),
    .edge_cfg (edge_cfg),
    .pol_cfg  (pol_cfg),
    .line_idx (line_idx),
    .sel      (sel)
  );

  assign line_hit = sel.hit;

  slot_irq_drive u_drive (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .sel       (sel),
    .cpu_irq   (cpu_irq)
  );

endmodule

// File: rtl/slot_irq_router_chk.sv
module slot_irq_router_chk #(
  parameter int SLOT_W   = 5,
  parameter int NUM_W    = 8,
  parameter int IRQ_BASE = 32,
  parameter int LINES    = 32,
  parameter int GFX_SLOT = 6,
  parameter int GFX_OFS  = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic [SLOT_W-1:0]        dev_slot,
  input logic [LINES-1:0]         edge_cfg,
  input logic [LINES-1:0]         pol_cfg,
  input logic [NUM_W-1:0]         irq_num,
  input logic                     line_hit,
  input logic [$clog2(LINES)-1:0] line_idx,
  input logic                     cpu_irq
);

  logic edge_bit;
  logic lvl_bit;
  logic hit_req;
  logic was_pulse;

  assign edge_bit = edge_cfg[line_idx];
  assign lvl_bit  = pol_cfg[line_idx];
  assign hit_req  = req_valid && line_hit;

  always_ff @(posedge clk) begin
    if (rst) was_pulse <= 1'b0;
    else     was_pulse <= hit_req && edge_bit;
  end

  assert_gfx_route_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dev_slot == SLOT_W'(GFX_SLOT)) |-> irq_num == NUM_W'(IRQ_BASE + GFX_OFS));

  assert_pulse_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (hit_req && edge_bit) |=> cpu_irq);

  assert_pulse_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (was_pulse && !hit_req) |=> !cpu_irq);

  assert_level_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (hit_req && !edge_bit) |=> cpu_irq == $past(lvl_bit));

  assert_miss_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (!hit_req && !was_pulse) |=> $stable(cpu_irq));

endmodule

bind slot_irq_router slot_irq_router_chk #(
  .SLOT_W(SLOT_W), .NUM_W(NUM_W), .IRQ_BASE(IRQ_BASE), .LINES(LINES),
  .GFX_SLOT(GFX_SLOT), .GFX_OFS(GFX_OFS)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .dev_slot(dev_slot),
  .edge_cfg(edge_cfg), .pol_cfg(pol_cfg), .irq_num(irq_num),
  .line_hit(line_hit), .line_idx(line_idx), .cpu_irq(cpu_irq)
);

// File: tb/tb_slot_irq_router.sv
module tb_slot_irq_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [4:0]  dev_slot = '0;
  logic [1:0]  dev_pin = '0;
  logic [31:0] edge_cfg;
  logic [31:0] pol_cfg;
  logic [7:0]  irq_num;
  logic        cpu_irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  slot_irq_router dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .dev_slot(dev_slot),
    .dev_pin(dev_pin), .edge_cfg(edge_cfg), .pol_cfg(pol_cfg),
    .irq_num(irq_num), .cpu_irq(cpu_irq)
  );

  // Monitor: one expected cpu_irq value per driven cycle.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (cpu_irq !== e) begin
          fails++;
          $display("FAIL %s cpu_irq actual=%0b expected=%0b", t, cpu_irq, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected<=5000 cycles", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic idle(input bit rst_v, input bit exp_irq, input string tag);
    @(negedge clk);
    rst       = rst_v;
    req_valid = 1'b0;
    exp_q.push_back(exp_irq);
    tag_q.push_back(tag);
  endtask

  task automatic req(input int slot, input int pin, input int exp_num,
                     input bit exp_irq, input string tag);
    @(negedge clk);
    rst       = 1'b0;
    req_valid = 1'b1;
    dev_slot  = 5'(slot);
    dev_pin   = 2'(pin);
    #1;
    checks++;
    if (irq_num !== 8'(exp_num)) begin
      fails++;
      $display("FAIL %s irq_num actual=%0d expected=%0d", tag, irq_num, exp_num);
    end
    exp_q.push_back(exp_irq);
    tag_q.push_back(tag);
  endtask

  initial begin
    edge_cfg = 32'h0000_0020;                        // line 5 pulses
    pol_cfg  = 32'h0000_2044;                        // lines 2, 6, 13 active high
    idle(1'b1, 1'b0, "R1 reset");
    idle(1'b0, 1'b0, "R1 after reset");
    req(5, 2, 34, 1'b1, "R2/R7 slot5 pin2 level high");
    idle(1'b0, 1'b1, "R7 level held");
    req(0, 1, 1, 1'b1, "R5/R9 slot0 passthrough holds");
    req(6, 3, 36, 1'b0, "R3/R8 slot6 level low");
    req(8, 0, 38, 1'b1, "R4 slot8 pin0");
    req(10, 1, 41, 1'b0, "R4 slot10 pin1");
    req(12, 3, 45, 1'b1, "R4 slot12 pin3");
    req(7, 0, 37, 1'b1, "R3/R6 slot7 pulse over high level");
    idle(1'b0, 1'b0, "R6 pulse falls");
    idle(1'b0, 1'b0, "R6 stays low");
    req(7, 2, 37, 1'b1, "R10 first pulse");
    req(7, 1, 37, 1'b1, "R10 second pulse");
    idle(1'b0, 1'b0, "R10 fall after last");
    req(13, 2, 2, 1'b0, "R5/R9 slot13 passthrough");
    req(31, 3, 3, 1'b0, "R5/R9 slot31 passthrough");
    req(7, 3, 37, 1'b1, "R6 pulse before miss");
    req(3, 0, 0, 1'b0, "R6/R9 miss right after pulse");
    req(5, 0, 32, 1'b0, "R2/R8 slot5 pin0 low");
    req(5, 2, 34, 1'b1, "R2 level high before reset");
    idle(1'b1, 1'b0, "R1 mid-run reset");
    idle(1'b0, 1'b0, "R1 low after reset");
    idle(1'b0, 1'b0, "drain");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule